// File: doc/BRIEF.md
# Single-Wire Serial Number Slave

This block is the slave end of an open-drain single-wire bus that carries nothing but a fixed 64-bit identity. It watches the line through a two-stage synchroniser and can only pull the line low, through the `bus_pull` enable. When the master holds the line low long enough, the block treats that as a bus reset. Once the line is released, the block answers with a presence pulse.

After presence the master writes one command byte. Depending on the byte, the block then does one of three things. It can shift out the whole identity, or it can take part in a bitwise search in which each ROM bit takes three slots: the bit, its complement, and the master's choice. For any other byte it stays silent until the next bus reset.

All timing comes from a one-microsecond strobe on `us_tick`. The identity and every duration are parameters. The identity keeps the family code 01h in its lowest byte, a 48-bit serial number above it, and a check byte in the top byte.

Top module: `ow_serial_slave`

## Requirements
- R1: After `rst_n` is released, `bus_pull` is 0. It stays 0 through any slots that arrive before a bus reset has been seen.
- R2: A line low for at least RESET_US ticks (default 480) is a bus reset. When the line is then released, the block produces a presence pulse.
- R3: The presence pulse starts PRES_WAIT_US ticks (default 30) after the line is seen high, plus at most a few clocks of synchroniser latency. It lasts PRES_LOW_US ticks (default 120).
- R4: A line low that is shorter than RESET_US ticks produces no presence pulse.
- R5: Command byte 33h, sent least significant bit first, starts a read of the 64 ROM bits, bit 0 first. The block answers each read slot for a 0 bit by pulling the line low for READ_HOLD_US ticks (default 15) from the falling edge it detects. For a 1 bit it leaves the line alone.
- R6: Command byte 0Fh starts the same 64-bit read as 33h.
- R7: Command bytes 55h and CCh leave the block silent, with no pull in any later slot, until the next bus reset.
- R8: Command byte F0h starts a search. For ROM bit i, in order from i = 0, the block answers a read slot with bit i and then a read slot with its inverse. It then samples a write slot. If the sampled value equals bit i, it moves on to bit i+1.
- R9: If the value sampled in a search write slot differs from the block's own bit, the block drops out and stays silent until the next bus reset.
- R10: A bus reset in the middle of a read or search aborts it. The block gives a fresh presence pulse and accepts a new command.
- R11: After the 64th ROM bit of a read or a search, and after any command byte other than 33h, 0Fh or F0h, the block pulls in no later slot until the next bus reset.
- R12: Write slots are sampled SAMPLE_US ticks (default 30) after the detected falling edge. A master low of 25 ticks therefore reads as 1, and a master low of 40 ticks reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| bus_in | input | 1 | Asynchronous sample of the bus line |
| bus_pull | output | 1 | 1 pulls the bus line low |

## Verification
Two functions can meet in the same cycle: the long-low detector and the slot engine. When a master reset lands in the middle of a read, the saturating low counter and the slot timer are both live. The abort must win, and no read hold may survive into the reset. The bench provokes this by issuing a bus reset after the 20th bit of a read. It judges the result by the presence timing that follows and by a complete, correct 64-bit read under the second read code. A second meeting point is the presence release, which coincides with the move into command reception. The bench judges this by the very first command bit after every presence pulse being taken correctly.

// File: rtl/ow_serial_slave.sv
module ow_serial_slave #(
  parameter logic [63:0] ROM_VALUE    = 64'h5A3C96E1D24B8701,
  parameter int          RESET_US     = 480,
  parameter int          PRES_WAIT_US = 30,
  parameter int          PRES_LOW_US  = 120,
  parameter int          SAMPLE_US    = 30,
  parameter int          READ_HOLD_US = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bus_in,
  output logic bus_pull
);
  localparam int TMAX1 = (PRES_LOW_US > PRES_WAIT_US) ? PRES_LOW_US : PRES_WAIT_US;
  localparam int TMAX2 = (SAMPLE_US > READ_HOLD_US) ? SAMPLE_US : READ_HOLD_US;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 2);
  localparam int LW    = $clog2(RESET_US + 1);

  localparam logic [TW-1:0] T_PW_LAST = TW'(PRES_WAIT_US - 1);
  localparam logic [TW-1:0] T_PL_LAST = TW'(PRES_LOW_US - 1);
  localparam logic [TW-1:0] T_SAMPLE  = TW'(SAMPLE_US);
  localparam logic [TW-1:0] T_HOLD    = TW'(READ_HOLD_US);
  localparam logic [LW-1:0] L_RESET   = LW'(RESET_US);

  typedef enum logic [2:0] {
    S_IDLE, S_RSTLOW, S_PWAIT, S_PLOW, S_CMD, S_READ, S_SRCH
  } state_t;

  state_t        state;
  logic [1:0]    sync;
  logic          line_prev;
  logic [LW-1:0] low_cnt;
  logic [TW-1:0] tcnt;
  logic          in_slot;
  logic          slot_rd;
  logic [5:0]    bit_idx;
  logic [2:0]    cmd_cnt;
  logic [7:0]    cmd_sr;
  logic [1:0]    phase;
  logic          pull_r;

  wire line_s   = sync[1];
  wire fall     = line_prev & ~line_s;
  wire long_low = (low_cnt == L_RESET);
  wire rom_bit  = ROM_VALUE[bit_idx];
  wire tx_bit   = (phase == 2'd1) ? ~rom_bit : rom_bit;
  wire slot_is_read = (state == S_READ) || (state == S_SRCH && phase != 2'd2);
  wire [7:0] next_cmd = {line_s, cmd_sr[7:1]};
  wire last_bit = (bit_idx == 6'd63);

  assign bus_pull = pull_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sync      <= 2'b11;
      line_prev <= 1'b1;
      low_cnt   <= '0;
      tcnt      <= '0;
      in_slot   <= 1'b0;
      slot_rd   <= 1'b0;
      bit_idx   <= '0;
      cmd_cnt   <= '0;
      cmd_sr    <= '0;
      phase     <= '0;
      pull_r    <= 1'b0;
    end else begin
      sync      <= {sync[0], bus_in};
      line_prev <= line_s;

      if (line_s)
        low_cnt <= '0;
      else if (us_tick && !long_low)
        low_cnt <= low_cnt + 1'b1;

      if (long_low && state != S_RSTLOW) begin
        state   <= S_RSTLOW;
        pull_r  <= 1'b0;
        in_slot <= 1'b0;
      end else begin
        case (state)
          S_IDLE: ;
          S_RSTLOW:
            if (line_s) begin
              state <= S_PWAIT;
              tcnt  <= '0;
            end
          S_PWAIT:
            if (us_tick) begin
              if (tcnt == T_PW_LAST) begin
                state  <= S_PLOW;
                tcnt   <= '0;
                pull_r <= 1'b1;
              end else
                tcnt <= tcnt + 1'b1;
            end
          S_PLOW:
            if (us_tick) begin
              if (tcnt == T_PL_LAST) begin
                state   <= S_CMD;
                pull_r  <= 1'b0;
                in_slot <= 1'b0;
                cmd_cnt <= '0;
              end else
                tcnt <= tcnt + 1'b1;
            end
          default: begin
            if (!in_slot) begin
              if (fall) begin
                in_slot <= 1'b1;
                tcnt    <= '0;
                slot_rd <= slot_is_read;
                pull_r  <= slot_is_read & ~tx_bit;
              end
            end else begin
              if (us_tick)
                tcnt <= tcnt + 1'b1;
              if (slot_rd && tcnt == T_HOLD) begin
                in_slot <= 1'b0;
                pull_r  <= 1'b0;
                if (state == S_READ) begin
                  if (last_bit) state <= S_IDLE;
                  else bit_idx <= bit_idx + 1'b1;
                end else
                  phase <= phase + 1'b1;
              end else if (!slot_rd && tcnt == T_SAMPLE) begin
                in_slot <= 1'b0;
                if (state == S_CMD) begin
                  cmd_sr  <= next_cmd;
                  cmd_cnt <= cmd_cnt + 1'b1;
                  if (cmd_cnt == 3'd7) begin
                    bit_idx <= '0;
                    phase   <= '0;
                    if (next_cmd == 8'h33 || next_cmd == 8'h0F)
                      state <= S_READ;
                    else if (next_cmd == 8'hF0)
                      state <= S_SRCH;
                    else
                      state <= S_IDLE;
                  end
                end else begin
                  phase <= '0;
                  if (line_s != rom_bit || last_bit)
                    state <= S_IDLE;
                  else
                    bit_idx <= bit_idx + 1'b1;
                end
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_serial_slave_chk.sv
module ow_serial_slave_chk #(
  parameter int RESET_US    = 480,
  parameter int PRES_LOW_US = 120
) (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic bus_in,
  input logic bus_pull
);
  localparam int CW = $clog2(RESET_US + 2);
  localparam logic [CW-1:0] C_SAT  = CW'(RESET_US + 1);
  localparam logic [CW-1:0] C_PULL = CW'(PRES_LOW_US + 1);
  localparam logic [CW-1:0] C_DEEP = CW'(PRES_LOW_US + 8);

  logic [CW-1:0] pull_run;
  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pull_run <= '0;
      low_run  <= '0;
    end else begin
      if (!bus_pull) pull_run <= '0;
      else if (us_tick && pull_run != C_SAT) pull_run <= pull_run + 1'b1;
      if (bus_in) low_run <= '0;
      else if (us_tick && low_run != C_SAT) low_run <= low_run + 1'b1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_pull);

  a_r3_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pull_run <= C_PULL);

  a_r10_quiet_in_long_low: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run > C_DEEP) |-> !bus_pull);

  a_r5_pull_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> (low_run <= CW'(4)));
endmodule

bind ow_serial_slave ow_serial_slave_chk #(
  .RESET_US(RESET_US), .PRES_LOW_US(PRES_LOW_US)
) chk_i (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in), .bus_pull(bus_pull)
);

// File: tb/ow_serial_slave_tb_top.sv
module ow_serial_slave_tb_top;
  localparam logic [63:0] ROM = 64'h5A3C96E1D24B8701;
  localparam int PW = 30, PL = 120, HOLD = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic bus_pull;
  wire  bus_line = ~(m_low | bus_pull);

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  ow_serial_slave #(.ROM_VALUE(ROM)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(1'b1), .bus_in(bus_line), .bus_pull(bus_pull)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_reset(input int low_len, output int wait_c, output int plen);
    @(posedge clk); #1 m_low = 1'b1;
    repeat (low_len) @(posedge clk);
    #1 m_low = 1'b0;
    wait_c = -1; plen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bus_pull) begin
        if (wait_c < 0) wait_c = i;
        plen++;
      end
    end
  endtask

  task automatic write_bit_t(input logic b, input int low_len);
    @(posedge clk); #1 m_low = 1'b1;
    repeat (low_len) @(posedge clk);
    #1 m_low = 1'b0;
    repeat (75 - low_len) @(posedge clk);
  endtask

  task automatic write_bit(input logic b);
    write_bit_t(b, b ? 6 : 60);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(output logic v, output int hold);
    @(posedge clk); #1 m_low = 1'b1;
    repeat (4) @(posedge clk);
    #1 m_low = 1'b0;
    v = 1'b1; hold = 0;
    for (int i = 0; i < 68; i++) begin
      @(negedge clk);
      if (i == 10) v = bus_line;
      if (bus_pull) hold++;
    end
  endtask

  task automatic std_reset(input string tag);
    int w, p;
    bus_reset(500, w, p);
    chk({tag, " presence seen"}, 64'(w >= PW && w <= PW + 6), 64'd1);
    chk({tag, " presence length"}, 64'(p >= PL - 1 && p <= PL + 1), 64'd1);
    idle(20);
  endtask

  task automatic read_bits(input int n, output logic [63:0] val, output int bad_hold);
    logic v; int h;
    val = '0; bad_hold = 0;
    for (int i = 0; i < n; i++) begin
      read_bit(v, h);
      val[i] = v;
      if (v == 1'b0 && (h < HOLD || h > HOLD + 2)) bad_hold++;
      if (v == 1'b1 && h != 0) bad_hold++;
    end
  endtask

  initial begin
    logic [63:0] got, rb, cb;
    int w, p, bh;
    logic b, c;
    int h;

    idle(5);
    rst_n = 1'b1;
    idle(1);
    chk("R1 pull after reset", 64'(bus_pull), 64'd0);
    read_bits(4, got, bh);
    chk("R1 silent before bus reset", got[3:0], 64'hF);

    bus_reset(500, w, p);
    chk("R2 presence after long low", 64'(w >= 0), 64'd1);
    chk("R3 presence delay", 64'(w >= PW && w <= PW + 6), 64'd1);
    chk("R3 presence length", 64'(p), 64'(PL));
    idle(20);

    bus_reset(300, w, p);
    chk("R4 short low no presence", 64'(p), 64'd0);
    idle(20);

    std_reset("R5");
    write_byte(8'h33);
    read_bits(64, got, bh);
    chk("R5 read 33h value", got, ROM);
    chk("R5 family byte", got[7:0], 64'h01);
    chk("R5 hold timing", 64'(bh), 64'd0);
    read_bits(4, got, bh);
    chk("R11 silent after 64 bits", got[3:0], 64'hF);

    std_reset("R10 first");
    write_byte(8'h0F);
    read_bits(20, got, bh);
    chk("R6 partial read", got[19:0], 64'(ROM[19:0]));
    std_reset("R10 abort");
    write_byte(8'h0F);
    read_bits(64, got, bh);
    chk("R10 read after abort", got, ROM);
    chk("R6 hold timing", 64'(bh), 64'd0);

    std_reset("R7 match");
    write_byte(8'h55);
    read_bits(8, got, bh);
    chk("R7 55h silent", got[7:0], 64'hFF);
    chk("R7 55h no pull", 64'(bh), 64'd0);
    std_reset("R7 skip");
    write_byte(8'hCC);
    read_bits(8, got, bh);
    chk("R7 CCh silent", got[7:0], 64'hFF);

    std_reset("R11");
    write_byte(8'hA5);
    read_bits(8, got, bh);
    chk("R11 unknown command silent", got[7:0], 64'hFF);

    std_reset("R8");
    write_byte(8'hF0);
    rb = '0; cb = '0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b, h);
      read_bit(c, h);
      rb[i] = b; cb[i] = c;
      write_bit(b);
    end
    chk("R8 search bits", rb, ROM);
    chk("R8 search complements", cb, ~ROM);
    read_bits(4, got, bh);
    chk("R11 silent after search", got[3:0], 64'hF);

    std_reset("R9");
    write_byte(8'hF0);
    for (int i = 0; i < 5; i++) begin
      read_bit(b, h);
      read_bit(c, h);
      write_bit(b);
    end
    read_bit(b, h);
    read_bit(c, h);
    chk("R9 bit5 before loss", 64'({b, c}), 64'({ROM[5], ~ROM[5]}));
    write_bit(~b);
    read_bits(6, got, bh);
    chk("R9 silent after loss", got[5:0], 64'h3F);
    chk("R9 no pull after loss", 64'(bh), 64'd0);

    std_reset("R12");
    for (int i = 0; i < 8; i++) begin
      logic bit_v;
      bit_v = 1'(8'h33 >> i);
      write_bit_t(bit_v, bit_v ? 25 : 40);
    end
    read_bits(8, got, bh);
    chk("R12 sample point", got[7:0], 64'(ROM[7:0]));

    summary();
    $finish;
  end
endmodule